// File: doc/BRIEF.md
# Clock Output Enable and Stop-Level Controller

This block decides, for each of a bank of differential clock outputs, whether the output toggles or rests at a programmed stop level. The decision draws on four sources. Each output has an enable pin whose active level can be programmed, and a software enable bit. Two global conditions apply to every output: PLL lock and power-down. The block runs in the output clock domain. The external pins and the two global conditions pass through a synchronizer before they are used.

Each output has three controls: a run flag that steers the clock through to the pad, two static levels for the true and complement legs while stopped, and a tri-state request. The run flag and the stop controls change only on the falling edge of the output clock. The true leg is low at that edge, so every period that reaches the pad is a whole one.

The software bits, the pin polarity bits and the stop code are configuration inputs. They are assumed to be held steady in the output clock domain.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, every run flag, stop level and tri-state request is 0.
- R2: Each pin acts at its own polarity. Pin i enables output i when its level equals polarity bit i: polarity 0 means active-low and polarity 1 means active-high.
- R3: Software enable bit i set to 0 holds output i stopped whatever pin i does. Bit i set to 1 hands control of output i to the pin.
- R4: The 2-bit stop code sets the levels of a stopped output as true/complement. Code 00 gives low/low, code 01 gives tri-state on both legs, code 10 gives high/low and code 11 gives low/high.
- R5: While the synchronized PLL lock is low, no output runs.
- R6: While the synchronized power-down input is high, every output is stopped and shows the programmed stop state.
- R7: After a pin changes, the output responds within 1 to 3 output-clock cycles.
- R8: The run flag and the stop controls change only on the falling edge of the clock.
- R9: For each output, at most one of the high-true, high-complement and tri-state requests is set, and none of them is set while the output runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Output clock (true leg) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_pin_i | input | N_OUT | Per-output enable pins, asynchronous |
| oe_pol_i | input | N_OUT | Active level of each pin (1 = active-high) |
| sw_en_i | input | N_OUT | Software enable bits (0 = forced stop) |
| stop_code_i | input | 2 | Stop-level encoding shared by all outputs |
| pll_lock_i | input | 1 | PLL lock, asynchronous |
| pwrdn_i | input | 1 | Power-down request, asynchronous, active-high |
| run_o | output | N_OUT | 1 = output toggles |
| stop_t_o | output | N_OUT | Stopped level of the true leg |
| stop_c_o | output | N_OUT | Stopped level of the complement leg |
| hiz_o | output | N_OUT | Tri-state request while stopped |

## Verification
The hardest timing to observe is the exact point where a pin change reaches the outputs. The change has to cross the synchronizer on rising edges and then land on a falling edge. The stimulus changes one pin a quarter period after a rising edge. It then samples the outputs at the rising-edge quarter and again just after the next falling edge. This shows that the change falls inside the latency window and also on the correct edge. Power-down and lock loss are applied while some outputs are already held off by software. This confirms that the global conditions override the per-output enables, and that releasing them gives back exactly the earlier per-output pattern.

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter int N_OUT       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] oe_pin_i,
  input  logic [N_OUT-1:0] oe_pol_i,
  input  logic [N_OUT-1:0] sw_en_i,
  input  logic [1:0]       stop_code_i,
  input  logic             pll_lock_i,
  input  logic             pwrdn_i,
  output logic [N_OUT-1:0] run_o,
  output logic [N_OUT-1:0] stop_t_o,
  output logic [N_OUT-1:0] stop_c_o,
  output logic [N_OUT-1:0] hiz_o
);
  localparam int SW = N_OUT + 2;

  logic [SW-1:0]    sync_q [SYNC_STAGES];
  logic [N_OUT-1:0] pin_s, want;
  logic             lock_s, pd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= {pwrdn_i, pll_lock_i, oe_pin_i};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_s  = sync_q[SYNC_STAGES-1][N_OUT-1:0];
  assign lock_s = sync_q[SYNC_STAGES-1][N_OUT];
  assign pd_s   = sync_q[SYNC_STAGES-1][N_OUT+1];
  assign want   = sw_en_i & ~(pin_s ^ oe_pol_i) & {N_OUT{lock_s & ~pd_s}};

  // falling edge: true leg is low, so only whole periods pass
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= '0;
      stop_t_o <= '0;
      stop_c_o <= '0;
      hiz_o    <= '0;
    end else begin
      run_o    <= want;
      stop_t_o <= ~want & {N_OUT{stop_code_i == 2'b10}};
      stop_c_o <= ~want & {N_OUT{stop_code_i == 2'b11}};
      hiz_o    <= ~want & {N_OUT{stop_code_i == 2'b01}};
    end
  end

  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert ((run_o | stop_t_o | stop_c_o | hiz_o) == '0);
    end
  end

  p_no_run_unlocked_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !lock_s |=> run_o == '0);

  p_pwrdn_stops_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pd_s |=> run_o == '0);

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    p_sw_off_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !sw_en_i[i] |=> !run_o[i]);

    p_hiz_code_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (stop_code_i == 2'b01 && !want[i]) |=> hiz_o[i] && !stop_t_o[i] && !stop_c_o[i]);

    p_stop_exclusive_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
      $onehot0({stop_t_o[i], stop_c_o[i], hiz_o[i]}) && !(run_o[i] && (stop_t_o[i] || stop_c_o[i] || hiz_o[i])));
  end
endmodule

// File: tb/clkout_gate_ctrl_tb_top.sv
module clkout_gate_ctrl_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, pol = '0, swen = '1;
  logic [1:0]   code = 2'b00;
  logic         lock = 1'b0, pd = 1'b0;
  logic [N-1:0] run, st, sc, hz;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  clkout_gate_ctrl #(.N_OUT(N), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .oe_pin_i(pin), .oe_pol_i(pol), .sw_en_i(swen),
    .stop_code_i(code), .pll_lock_i(lock), .pwrdn_i(pd),
    .run_o(run), .stop_t_o(st), .stop_c_o(sc), .hiz_o(hz));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #5;
  endtask

  task automatic t_reset_r1();
    #25;
    chk("R1 run in reset", run, '0);
    chk("R1 levels in reset", st | sc | hz, '0);
    @(posedge clk); #5 rst_n = 1'b1;
    settle();
    chk("R1 run after reset", run, '0);
    chk("R1 levels after reset", st | sc | hz, '0);
  endtask

  task automatic t_lock_r5();
    chk("R5 unlocked stays off", run, '0);
    lock = 1'b1;
    settle();
    chk("R5 locked all run", run, 8'hFF);
    lock = 1'b0;
    settle();
    chk("R5 lock loss stops all", run, 8'h00);
    lock = 1'b1;
    settle();
  endtask

  task automatic t_polarity_r2();
    pin = 8'h0F; pol = 8'h00;
    settle();
    chk("R2 active-low pins", run, 8'hF0);
    pol = 8'hFF;
    settle();
    chk("R2 active-high pins", run, 8'h0F);
    pol = 8'h3C;
    settle();
    chk("R2 mixed polarity", run, 8'hCC);
    pin = 8'h00; pol = 8'h00;
    settle();
  endtask

  task automatic t_swen_r3();
    swen = 8'h5A;
    settle();
    chk("R3 sw mask", run, 8'h5A);
    pin = 8'hA5;
    settle();
    chk("R3 masked pins ignored", run, 8'h5A);
    pin = 8'hFF; pol = 8'hFF;
    settle();
    chk("R3 sw off beats active pin", run, 8'h5A);
    pin = 8'h00; pol = 8'h00; swen = 8'hFF;
    settle();
  endtask

  task automatic t_code_r4_r9();
    swen = 8'h0F;
    code = 2'b00; settle();
    chk("R4 code00 true", st, 8'h00); chk("R4 code00 comp", sc, 8'h00); chk("R4 code00 hiz", hz, 8'h00);
    code = 2'b01; settle();
    chk("R4 code01 hiz", hz, 8'hF0); chk("R9 code01 levels", st | sc, 8'h00);
    code = 2'b10; settle();
    chk("R4 code10 true", st, 8'hF0); chk("R4 code10 comp", sc, 8'h00); chk("R9 code10 hiz", hz, 8'h00);
    code = 2'b11; settle();
    chk("R4 code11 comp", sc, 8'hF0); chk("R4 code11 true", st, 8'h00);
    chk("R9 running quiet", (st | sc | hz) & run, 8'h00);
  endtask

  task automatic t_pwrdn_r6();
    code = 2'b10; pd = 1'b1;
    settle();
    chk("R6 pwrdn run", run, 8'h00);
    chk("R6 pwrdn stop level", st, 8'hFF);
    pd = 1'b0;
    settle();
    chk("R6 release restores", run, 8'h0F);
    swen = 8'hFF; code = 2'b00;
    settle();
  endtask

  task automatic t_latency_r7_r8();
    chk("R7 start all run", run, 8'hFF);
    @(posedge clk); #5 pin = 8'h01;
    @(posedge clk); #5 chk("R7 no change after 1 cycle", run, 8'hFF);
    @(posedge clk); #5 chk("R8 unchanged before falling edge", run, 8'hFF);
    #10 chk("R8 changed right after falling edge", run, 8'hFE);
    @(posedge clk); #5 chk("R7 stopped within 3 cycles", run, 8'hFE);
    pin = 8'h00;
    settle();
    chk("R7 restarted", run, 8'hFF);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_lock_r5();
    t_polarity_r2();
    t_swen_r3();
    t_code_r4_r9();
    t_pwrdn_r6();
    t_latency_r7_r8();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule